// File: doc/BRIEF.md
# H-Bridge Fault and Power-Mode Supervisor

This block decides, every clock cycle, which of the four half-bridges of a dual H-bridge motor driver may drive and which must sit in Hi-Z. It watches a sleep request pin and a set of digital fault flags from analog comparators: supply undervoltage, overtemperature, and per-half-bridge overcurrent and open load. From these it derives per-half-bridge enables, an active-low fault output and a ready flag that tells the input logic the bridges accept commands.

Each fault has its own isolation scope and its own recovery rule. Overcurrent disables one bridge, both bridges or a single half-bridge depending on the bridge interface mode, and recovers through a timed retry. Undervoltage and overtemperature disable everything and recover when their flag clears. Open load is latched until a latch-clear pulse or reset, and only disables outputs when a configuration input asks for it. Sleep entry, wake-up and retry times are counted in clock cycles set by parameters. All asynchronous inputs pass through two-flop synchronizers first.

Top module: `hbs_supervisor`

## Requirements
- R1: After the synchronized sleep request goes low, the bridges keep their state for SLEEP_DLY cycles, then all enables go to 0 and ready goes to 0; they stay so while asleep.
- R2: After the synchronized sleep request goes high, ready rises after exactly WAKE_DLY cycles; all enables stay 0 until ready is 1.
- R3: During wake-up, fault_n is 0 for exactly PULSE_LEN cycles starting with the first wake cycle.
- R4: While the undervoltage flag is set, all enables are 0 and ready is 0; both return on their own once the flag clears.
- R5: Overcurrent isolation scope by mode (mode code 0 = four-pin, 1 = two-pin: half-bridges 0,1 form bridge A and 2,3 form bridge B, the whole bridge of the flagged half goes Hi-Z; 2 = parallel: all four; 3 = independent: only the flagged half-bridge). Enable bit i drives half-bridge i, 1 = drive.
- R6: A single-cycle overcurrent flag disables its scope for exactly RETRY_DLY cycles; if the flag is still set when the retry time ends, the scope stays disabled and the retry restarts.
- R7: An open-load flag latches per half-bridge and holds fault_n low until olatch_clr is 1 for a cycle or reset; with ol_hiz_en = 0 the bridges keep driving, with ol_hiz_en = 1 the latched half-bridges are isolated with the R5 scope.
- R8: While the overtemperature flag is set, all enables are 0 but ready stays 1; recovery is automatic when the flag clears.
- R9: fault_n is 0 whenever undervoltage, overtemperature, an overcurrent retry or an open-load latch is active.
- R10: With several causes active, the disabled set is the union of the sets each cause disables on its own.
- R11: Every asynchronous input (sleep request and fault flags) takes effect two clock edges after it changes, never one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, also clears open-load latches |
| sleep_n | input | 1 | Sleep request, 0 = sleep, 1 = run (asynchronous) |
| uv_flag | input | 1 | Supply undervoltage comparator flag (asynchronous) |
| ot_flag | input | 1 | Overtemperature comparator flag (asynchronous) |
| oc_flag | input | 4 | Per-half-bridge overcurrent flags (asynchronous) |
| ol_flag | input | 4 | Per-half-bridge open-load flags (asynchronous) |
| mode | input | 2 | Bridge interface mode, codes as in R5 |
| ol_hiz_en | input | 1 | 1 = isolate half-bridges with a latched open load |
| olatch_clr | input | 1 | Synchronous open-load latch clear |
| hb_en | output | 4 | Per-half-bridge enable, 0 = Hi-Z |
| fault_n | output | 1 | Active-low fault indication |
| ready | output | 1 | Bridges awake and accepting inputs |

## Verification
The bench builds the block with SLEEP_DLY = 12, WAKE_DLY = 10, RETRY_DLY = 16 and PULSE_LEN = 3 instead of the much longer defaults. These short windows let it measure the exact sleep, wake, power-up pulse and retry lengths cycle by cycle, run dozens of random overcurrent events across all four modes, and hold a flag across several retry expiries to see the restart, all within a short run.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

   localparam int HB_N = 4;

   typedef enum logic [1:0] {
      MODE_FOUR = 2'd0,
      MODE_TWO  = 2'd1,
      MODE_PAR  = 2'd2,
      MODE_IND  = 2'd3
   } hbs_mode_e;

   typedef enum logic [1:0] {
      PWR_SLEEP = 2'd0,
      PWR_WAKE  = 2'd1,
      PWR_RUN   = 2'd2,
      PWR_DOZE  = 2'd3
   } hbs_pwr_e;

   // Widen a per-half-bridge fault vector to the set of half-bridges it isolates
   function automatic logic [HB_N-1:0] iso_scope(input hbs_mode_e m,
                                                 input logic [HB_N-1:0] src);
      logic [HB_N-1:0] r;
      r = '0;
      for (int i = 0; i < HB_N; i++) begin
         if (src[i]) begin
            case (m)
               MODE_PAR: r = '1;
               MODE_IND: r[i] = 1'b1;
               default:  r[(i/2)*2 +: 2] = 2'b11;
            endcase
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hbs_power_fsm.sv
module hbs_power_fsm
   import hbs_pkg::*;
#(
   parameter int SLEEP_DLY = 1000,
   parameter int WAKE_DLY  = 5000,
   parameter int PULSE_LEN = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_req,
   output logic pwr_on,
   output logic wake_pulse
);
   localparam int MAXD = (SLEEP_DLY > WAKE_DLY) ? SLEEP_DLY : WAKE_DLY;
   localparam int CW   = $clog2(MAXD + 1);
   localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_DLY - 1);
   localparam logic [CW-1:0] SLEEP_LAST = CW'(SLEEP_DLY - 1);
   localparam logic [CW-1:0] PULSE_END  = CW'(PULSE_LEN);

   generate
      if (SLEEP_DLY < 1 || WAKE_DLY < 1) begin : g_bad_dly
         $error("hbs_power_fsm: delays must be at least 1");
      end
      if (PULSE_LEN < 1 || PULSE_LEN > WAKE_DLY) begin : g_bad_pulse
         $error("hbs_power_fsm: PULSE_LEN must lie in 1..WAKE_DLY");
      end
   endgenerate

   hbs_pwr_e        state;
   logic [CW-1:0]   cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PWR_SLEEP;
         cnt   <= '0;
      end else begin
         case (state)
            PWR_SLEEP: begin
               cnt <= '0;
               if (run_req) state <= PWR_WAKE;
            end
            PWR_WAKE: begin
               if (!run_req) begin
                  state <= PWR_SLEEP;
                  cnt   <= '0;
               end else if (cnt == WAKE_LAST) begin
                  state <= PWR_RUN;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PWR_RUN: begin
               cnt <= '0;
               if (!run_req) state <= PWR_DOZE;
            end
            default: begin
               if (run_req) begin
                  state <= PWR_RUN;
                  cnt   <= '0;
               end else if (cnt == SLEEP_LAST) begin
                  state <= PWR_SLEEP;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign pwr_on     = (state == PWR_RUN) || (state == PWR_DOZE);
   assign wake_pulse = (state == PWR_WAKE) && (cnt < PULSE_END);

   // R2: wake phase cannot end early while the request holds
   assert_wake_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PWR_WAKE && run_req && cnt != WAKE_LAST) |=> (state == PWR_WAKE));

   // R1: sleep is entered when the doze window expires
   assert_sleep_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PWR_DOZE && !run_req && cnt == SLEEP_LAST) |=> (state == PWR_SLEEP));

   // R1: the bridges stay powered through the doze window
   assert_doze_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PWR_RUN && !run_req) |=> pwr_on);
endmodule

// File: rtl/hbs_oc_retry.sv
module hbs_oc_retry #(
   parameter int RETRY_DLY = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oc_s,
   output logic hold
);
   localparam int CW = $clog2(RETRY_DLY + 1);
   localparam logic [CW-1:0] LAST = CW'(RETRY_DLY - 1);

   generate
      if (RETRY_DLY < 1) begin : g_bad_retry
         $error("hbs_oc_retry: RETRY_DLY must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= 1'b0;
         cnt  <= '0;
      end else if (!hold) begin
         cnt <= '0;
         if (oc_s) hold <= 1'b1;
      end else if (cnt == LAST) begin
         cnt  <= '0;
         hold <= oc_s;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R6: a flag seen while idle starts a retry window
   assert_retry_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && oc_s) |=> hold);

   // R6: a flag still present at expiry restarts the window
   assert_retry_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && cnt == LAST && oc_s) |=> (hold && cnt == '0));

   // R6: the window never ends before its count is reached
   assert_retry_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && cnt != LAST) |=> hold);
endmodule

// File: rtl/hbs_supervisor.sv
module hbs_supervisor
   import hbs_pkg::*;
#(
   parameter int SLEEP_DLY   = 1000,
   parameter int WAKE_DLY    = 5000,
   parameter int PULSE_LEN   = 50,
   parameter int RETRY_DLY   = 20000,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sleep_n,
   input  logic            uv_flag,
   input  logic            ot_flag,
   input  logic [HB_N-1:0] oc_flag,
   input  logic [HB_N-1:0] ol_flag,
   input  logic [1:0]      mode,
   input  logic            ol_hiz_en,
   input  logic            olatch_clr,
   output logic [HB_N-1:0] hb_en,
   output logic            fault_n,
   output logic            ready
);
   localparam int SW = 3 + 2*HB_N;

   logic [SW-1:0]   raw_v, syn_v;
   logic            s_run, s_uv, s_ot;
   logic [HB_N-1:0] s_oc, s_ol;
   logic [HB_N-1:0] oc_hold, ol_lat, iso_mask;
   logic            pwr_on, wake_pulse;
   hbs_mode_e       mode_e;

   assign raw_v = {sleep_n, uv_flag, ot_flag, oc_flag, ol_flag};

   hbs_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v));

   assign {s_run, s_uv, s_ot, s_oc, s_ol} = syn_v;

   hbs_power_fsm #(.SLEEP_DLY(SLEEP_DLY), .WAKE_DLY(WAKE_DLY), .PULSE_LEN(PULSE_LEN)) u_pwr (
      .clk(clk), .rst_n(rst_n), .run_req(s_run),
      .pwr_on(pwr_on), .wake_pulse(wake_pulse));

   generate
      for (genvar h = 0; h < HB_N; h++) begin : g_hb
         hbs_oc_retry #(.RETRY_DLY(RETRY_DLY)) u_retry (
            .clk(clk), .rst_n(rst_n), .oc_s(s_oc[h]), .hold(oc_hold[h]));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          ol_lat[h] <= 1'b0;
            else if (olatch_clr) ol_lat[h] <= 1'b0;
            else if (s_ol[h])    ol_lat[h] <= 1'b1;
         end
      end
   endgenerate

   assign mode_e = hbs_mode_e'(mode);

   always_comb begin
      iso_mask = iso_scope(mode_e, oc_hold);
      if (ol_hiz_en) iso_mask = iso_mask | iso_scope(mode_e, ol_lat);
      if (!pwr_on || s_uv || s_ot) iso_mask = '1;
   end

   assign hb_en   = ~iso_mask;
   assign ready   = pwr_on && !s_uv;
   assign fault_n = !(s_uv || s_ot || (|oc_hold) || (|ol_lat) || wake_pulse);

   // R1: no half-bridge drives while powered down
   assert_asleep_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |-> (hb_en == '0 && !ready));

   // R4: undervoltage isolates everything and drops ready
   assert_uv_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
      s_uv |-> (hb_en == '0 && !ready && !fault_n));

   // R8: overtemperature isolates everything
   assert_ot_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
      s_ot |-> (hb_en == '0 && !fault_n));

   // R7: a latched open load keeps the fault output low
   assert_ol_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|ol_lat) |-> !fault_n);

   // R9: a running retry keeps the fault output low
   assert_oc_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|oc_hold) |-> !fault_n);

   // R5: independent mode isolates exactly the retrying half-bridges
   assert_ind_scope_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == MODE_IND && !ol_hiz_en && pwr_on && !s_uv && !s_ot) |-> (hb_en == ~oc_hold));
endmodule

// File: tb/hbs_supervisor_tb_top.sv
module hbs_supervisor_tb_top;
   localparam int SLP = 12, WAK = 10, PUL = 3, RTY = 16;
   localparam int LAT = 2;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       sleep_n = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0;
   logic [3:0] oc_flag = '0, ol_flag = '0;
   logic [1:0] mode = 2'd0;
   logic       ol_hiz_en = 1'b0, olatch_clr = 1'b0;
   logic [3:0] hb_en;
   logic       fault_n, ready;
   int         n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   hbs_supervisor #(.SLEEP_DLY(SLP), .WAKE_DLY(WAK), .PULSE_LEN(PUL),
                    .RETRY_DLY(RTY), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .uv_flag(uv_flag),
      .ot_flag(ot_flag), .oc_flag(oc_flag), .ol_flag(ol_flag), .mode(mode),
      .ol_hiz_en(ol_hiz_en), .olatch_clr(olatch_clr),
      .hb_en(hb_en), .fault_n(fault_n), .ready(ready));

   // Expected disabled set for one flagged half-bridge
   function automatic logic [3:0] exp_off(input logic [1:0] m, input int idx);
      if (m == 2'd2)      return 4'b1111;
      else if (m == 2'd3) return 4'b0001 << idx;
      else if (idx < 2)   return 4'b0011;
      else                return 4'b1100;
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      int cnt_nr, cnt_fl, cnt_on, cnt_off, idx;
      logic [1:0] m;
      logic [3:0] seen;
      void'($urandom(32'd24680));

      tick(3);
      // reset state
      check(hb_en == 4'h0 && !ready && fault_n, "R1 reset", {hb_en, ready, fault_n}, 6'b000001);
      rst_n = 1'b1;
      tick(3);
      check(hb_en == 4'h0 && !ready, "R1 asleep", {hb_en, ready}, 5'b0);

      // wake-up timing and power-up pulse
      sleep_n = 1'b1;
      cnt_nr = 0; cnt_fl = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (ready) break;
         cnt_nr++;
         if (!fault_n) cnt_fl++;
         if (hb_en != 4'h0) check(1'b0, "R2 enable during wake", hb_en, 0);
      end
      check(cnt_nr == WAK + LAT, "R2 wake length", cnt_nr, WAK + LAT);
      check(cnt_fl == PUL, "R3 power-up pulse", cnt_fl, PUL);
      check(hb_en == 4'hF && fault_n, "R2 running", {hb_en, fault_n}, 5'b11111);

      // R11: one edge after a flag change nothing happens yet
      uv_flag = 1'b1;
      tick(1);
      check(hb_en == 4'hF, "R11 one edge", hb_en, 4'hF);
      tick(1);
      check(hb_en == 4'h0, "R11 two edges", hb_en, 4'h0);
      // R4 undervoltage
      tick(2);
      check(hb_en == 4'h0 && !ready && !fault_n, "R4 uv", {hb_en, ready, fault_n}, 6'b0);
      uv_flag = 1'b0;
      tick(3);
      check(hb_en == 4'hF && ready && fault_n, "R4 uv recover", {hb_en, ready, fault_n}, 6'b111111);

      // R8 overtemperature
      ot_flag = 1'b1;
      tick(3);
      check(hb_en == 4'h0 && ready && !fault_n, "R8 ot", {hb_en, ready, fault_n}, 6'b000010);
      ot_flag = 1'b0;
      tick(3);
      check(hb_en == 4'hF && fault_n, "R8 ot recover", {hb_en, fault_n}, 5'b11111);

      // R5/R6 random single-cycle overcurrent events
      for (int k = 0; k < 40; k++) begin
         m = 2'($urandom_range(0, 3));
         idx = $urandom_range(0, 3);
         mode = m;
         tick(1);
         oc_flag[idx] = 1'b1;
         tick(1);
         oc_flag[idx] = 1'b0;
         seen = 4'hF;
         for (int i = 0; i < 10; i++) begin
            if (hb_en != 4'hF) break;
            tick(1);
         end
         seen = hb_en;
         cnt_off = 0;
         for (int i = 0; i < 4 * RTY; i++) begin
            if (hb_en == 4'hF) break;
            cnt_off++;
            tick(1);
         end
         check(seen == ~exp_off(m, idx), "R5 oc scope", seen, ~exp_off(m, idx));
         check(cnt_off == RTY, "R6 retry length", cnt_off, RTY);
      end

      // R6 persistent overcurrent restarts the retry
      mode = 2'd3;
      oc_flag[2] = 1'b1;
      tick(3 * RTY);
      check(hb_en == 4'b1011 && !fault_n, "R6 persistent oc", {hb_en, fault_n}, 5'b10110);
      oc_flag[2] = 1'b0;
      tick(2 * RTY + 4);
      check(hb_en == 4'hF && fault_n, "R6 oc released", {hb_en, fault_n}, 5'b11111);

      // R7 open-load latch
      mode = 2'd0;
      ol_flag[1] = 1'b1;
      tick(1);
      ol_flag[1] = 1'b0;
      tick(5);
      check(!fault_n && hb_en == 4'hF, "R7 ol latched, bridges run", {hb_en, fault_n}, 5'b11110);
      ol_hiz_en = 1'b1;
      tick(1);
      check(hb_en == 4'b1100, "R7 ol isolate four-pin", hb_en, 4'b1100);
      mode = 2'd3;
      tick(1);
      check(hb_en == 4'b1101, "R7 ol isolate independent", hb_en, 4'b1101);

      // R10 union of open-load and overcurrent masks
      oc_flag[3] = 1'b1;
      tick(1);
      oc_flag[3] = 1'b0;
      tick(3);
      check(hb_en == 4'b0101, "R10 combined mask", hb_en, 4'b0101);
      tick(RTY + 2);
      check(hb_en == 4'b1101 && !fault_n, "R9 ol still latched", {hb_en, fault_n}, 5'b11010);
      olatch_clr = 1'b1;
      tick(1);
      olatch_clr = 1'b0;
      tick(1);
      check(hb_en == 4'hF && fault_n, "R7 latch cleared", {hb_en, fault_n}, 5'b11111);
      ol_hiz_en = 1'b0;

      // R1 sleep entry delay
      sleep_n = 1'b0;
      cnt_on = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (hb_en == 4'h0) break;
         cnt_on++;
      end
      check(cnt_on == SLP + LAT, "R1 sleep delay", cnt_on, SLP + LAT);
      check(!ready, "R1 ready low asleep", ready, 0);

      finish_run();
   end
endmodule